// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block is the sequencing logic of one DMA channel. Software points it at a table of descriptors in memory and sets an enable bit. The walker then reads the table one entry at a time over a single-outstanding memory read port. Each entry is two 32-bit words: a region base address, and a control word that carries a 16-bit byte count and two flag bits. The walker presents the decoded region to the data mover and waits for the mover to report the region finished. It then moves on to the next entry.

The walker never keeps a descriptor once its region is done. Every region is read again from memory, so software may rewrite the table between passes. Dropping the enable bit abandons the walk at any point. A read that is already in flight is allowed to return, and its data is thrown away. The next enable always begins at the table start.

The walk ends at an entry whose end flag is set. The walker then holds a done indication and issues no further reads until enable is cleared. An entry can also ask for a one-cycle interrupt pulse when its region completes.

Top module: `sg_desc_walker`

## Requirements
- R1: A table pointer write stores the written address with its two low bits forced to zero; the first descriptor read of a walk uses that aligned address.
- R2: When enable is high and the walker is idle, it reads the entry's first word at the current entry address and then its second word at that address plus 4, one read at a time. A request holds its address until it is accepted.
- R3: After both words return, the walker presents a region. Its base is the first word. Its length is bits 15:0 of the second word. The region stays valid and unchanged until the data mover reports it done.
- R4: A byte count of zero in bits 15:0 is presented as a length of 65536.
- R5: When a region without the end flag completes, the next entry is read at the previous entry address plus 8.
- R6: Bit 31 of the second word marks the last entry. When that region completes, the walker raises its done output and issues no further reads or regions until enable is cleared.
- R7: When a region whose second word has bit 30 set completes, the interrupt output pulses high for exactly one cycle. A region without bit 30 produces no pulse.
- R8: Descriptors are not cached. Each new walk reads every entry from memory again and presents the values memory holds at that time.
- R9: If enable is cleared while a read is in flight, the walker waits for that response and discards it: no region is presented from it. The next enable reads from the table start.
- R10: Clearing enable while a region is presented drops the region valid output on the next cycle. Re-enabling restarts the walk at the table start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_wr | input | 1 | Table pointer write strobe |
| ptr_wdata | input | 32 | Table pointer write value |
| chan_en | input | 1 | Channel enable level |
| rd_valid | output | 1 | Descriptor read request |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_addr | output | 32 | Byte address of the requested word |
| rsp_valid | input | 1 | Read response strobe |
| rsp_data | input | 32 | Read response word |
| rgn_valid | output | 1 | Region presented to the data mover |
| rgn_base | output | 32 | Region base address |
| rgn_len | output | 17 | Region length in bytes (1 to 65536) |
| rgn_done | input | 1 | Data mover reports region finished |
| tbl_end | output | 1 | Last entry's region has completed |
| rgn_irq | output | 1 | One-cycle interrupt pulse |

## Verification
Several properties are checked on every cycle. An unaccepted read request must keep its address. A presented region must stay unchanged until it is done, and its length is never zero. No read is issued while a region is presented or after the table end. A cleared enable removes the region within one cycle. Interrupt pulses never last longer than a cycle. Other behaviour can be shown only by the bench's scenarios: the sequence of addresses read, the decoding of each entry, the absence of caching across walks, and the discarding of a response that returns after an abort.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ_LO,
      ST_WAIT_LO,
      ST_REQ_HI,
      ST_WAIT_HI,
      ST_REGION,
      ST_FINISHED,
      ST_DRAIN
   } sgw_state_e;

   localparam int unsigned WORD_BITS  = 32;
   localparam int unsigned WORD_BYTES = WORD_BITS / 8;
endpackage

// File: rtl/sgw_tbl_ptr.sv
module sgw_tbl_ptr #(
   parameter int unsigned AW         = 32,
   parameter int unsigned DESC_WORDS = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_data,
   input  logic          load,
   input  logic          adv,
   input  logic          hi_sel,
   output logic [AW-1:0] req_addr
);
   localparam int unsigned ALIGN_BITS = $clog2(sgw_pkg::WORD_BYTES);
   localparam int unsigned STEP       = DESC_WORDS * sgw_pkg::WORD_BYTES;

   if (AW <= ALIGN_BITS + 1) begin : g_bad_aw
      $error("sgw_tbl_ptr: address width too small");
   end
   if (DESC_WORDS != 2) begin : g_bad_words
      $error("sgw_tbl_ptr: descriptor must be two words");
   end

   logic [AW-1:0] tbl_q;
   logic [AW-1:0] cur_q;
   logic          unused_lsb;

   assign unused_lsb = ^wr_data[ALIGN_BITS-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tbl_q <= '0;
      end else if (wr_en) begin
         tbl_q <= {wr_data[AW-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= '0;
      end else if (load) begin
         cur_q <= tbl_q;
      end else if (adv) begin
         cur_q <= cur_q + AW'(STEP);
      end
   end

   assign req_addr = hi_sel ? (cur_q + AW'(sgw_pkg::WORD_BYTES)) : cur_q;

   AST_TBL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wr_en) |-> tbl_q[ALIGN_BITS-1:0] == '0); // R1
endmodule

// File: rtl/sgw_desc_decode.sv
module sgw_desc_decode #(
   parameter int unsigned AW          = 32,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned EOT_BIT     = 31,
   parameter int unsigned IRQ_BIT     = 30,
   parameter bit          ZERO_IS_MAX = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cap_lo,
   input  logic                          cap_hi,
   input  logic [sgw_pkg::WORD_BITS-1:0] rsp_data,
   output logic [AW-1:0]                 base,
   output logic [CNT_W:0]                len,
   output logic                          last,
   output logic                          irq_req
);
   localparam int unsigned WB = sgw_pkg::WORD_BITS;

   if (AW > WB) begin : g_bad_aw
      $error("sgw_desc_decode: base wider than a word");
   end
   if (CNT_W >= IRQ_BIT || CNT_W >= EOT_BIT) begin : g_bad_cnt
      $error("sgw_desc_decode: count overlaps flag bits");
   end
   if (EOT_BIT == IRQ_BIT || EOT_BIT >= WB || IRQ_BIT >= WB) begin : g_bad_flags
      $error("sgw_desc_decode: flag positions invalid");
   end

   logic [AW-1:0]    base_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last_q;
   logic             irq_q;
   logic             unused_bits;

   assign unused_bits = ^rsp_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= '0;
      end else if (cap_lo) begin
         base_q <= rsp_data[AW-1:0];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         last_q <= 1'b0;
         irq_q  <= 1'b0;
      end else if (cap_hi) begin
         cnt_q  <= rsp_data[CNT_W-1:0];
         last_q <= rsp_data[EOT_BIT];
         irq_q  <= rsp_data[IRQ_BIT];
      end
   end

   if (ZERO_IS_MAX) begin : g_zero_max
      assign len = (cnt_q == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt_q};
   end else begin : g_zero_plain
      assign len = {1'b0, cnt_q};
   end

   assign base    = base_q;
   assign last    = last_q;
   assign irq_req = irq_q;
endmodule

// File: rtl/sgw_seq_fsm.sv
module sgw_seq_fsm
   import sgw_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic req_ready,
   input  logic rsp_valid,
   input  logic rgn_done,
   input  logic d_last,
   input  logic d_irq,
   output logic load,
   output logic adv,
   output logic hi_sel,
   output logic cap_lo,
   output logic cap_hi,
   output logic req_valid,
   output logic rgn_valid,
   output logic finished,
   output logic irq
);
   sgw_state_e st_q;
   sgw_state_e st_d;
   logic       irq_set;
   logic       irq_q;

   always_comb begin
      st_d    = st_q;
      load    = 1'b0;
      adv     = 1'b0;
      cap_lo  = 1'b0;
      cap_hi  = 1'b0;
      irq_set = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (en) begin
               load = 1'b1;
               st_d = ST_REQ_LO;
            end
         end
         ST_REQ_LO: begin
            if (req_ready)  st_d = en ? ST_WAIT_LO : ST_DRAIN;
            else if (!en)   st_d = ST_IDLE;
         end
         ST_WAIT_LO: begin
            if (rsp_valid) begin
               if (en) begin
                  cap_lo = 1'b1;
                  st_d   = ST_REQ_HI;
               end else begin
                  st_d = ST_IDLE;
               end
            end else if (!en) begin
               st_d = ST_DRAIN;
            end
         end
         ST_REQ_HI: begin
            if (req_ready)  st_d = en ? ST_WAIT_HI : ST_DRAIN;
            else if (!en)   st_d = ST_IDLE;
         end
         ST_WAIT_HI: begin
            if (rsp_valid) begin
               if (en) begin
                  cap_hi = 1'b1;
                  st_d   = ST_REGION;
               end else begin
                  st_d = ST_IDLE;
               end
            end else if (!en) begin
               st_d = ST_DRAIN;
            end
         end
         ST_REGION: begin
            if (!en) begin
               st_d = ST_IDLE;
            end else if (rgn_done) begin
               irq_set = d_irq;
               if (d_last) begin
                  st_d = ST_FINISHED;
               end else begin
                  adv  = 1'b1;
                  st_d = ST_REQ_LO;
               end
            end
         end
         ST_FINISHED: begin
            if (!en) st_d = ST_IDLE;
         end
         ST_DRAIN: begin
            if (rsp_valid) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         irq_q <= 1'b0;
      end else begin
         st_q  <= st_d;
         irq_q <= irq_set;
      end
   end

   assign req_valid = (st_q == ST_REQ_LO) || (st_q == ST_REQ_HI);
   assign hi_sel    = (st_q == ST_REQ_HI);
   assign rgn_valid = (st_q == ST_REGION);
   assign finished  = (st_q == ST_FINISHED);
   assign irq       = irq_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready && en |=> req_valid && $stable(hi_sel)); // R2
   AST_NO_REQ_IN_REGION: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_valid |-> !req_valid); // R8
   AST_END_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      finished |-> !req_valid && !rgn_valid); // R6
   AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !rgn_valid); // R10
   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq); // R7
endmodule

// File: rtl/sg_desc_walker.sv
module sg_desc_walker #(
   parameter int unsigned AW          = 32,
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned EOT_BIT     = 31,
   parameter int unsigned IRQ_BIT     = 30,
   parameter bit          ZERO_IS_MAX = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          ptr_wr,
   input  logic [AW-1:0]                 ptr_wdata,
   input  logic                          chan_en,
   output logic                          rd_valid,
   input  logic                          rd_ready,
   output logic [AW-1:0]                 rd_addr,
   input  logic                          rsp_valid,
   input  logic [sgw_pkg::WORD_BITS-1:0] rsp_data,
   output logic                          rgn_valid,
   output logic [AW-1:0]                 rgn_base,
   output logic [CNT_W:0]                rgn_len,
   input  logic                          rgn_done,
   output logic                          tbl_end,
   output logic                          rgn_irq
);
   logic load, adv, hi_sel, cap_lo, cap_hi, d_last, d_irq;

   sgw_tbl_ptr #(.AW(AW), .DESC_WORDS(2)) u_ptr (
      .clk(clk), .rst_n(rst_n), .wr_en(ptr_wr), .wr_data(ptr_wdata),
      .load(load), .adv(adv), .hi_sel(hi_sel), .req_addr(rd_addr)
   );

   sgw_desc_decode #(
      .AW(AW), .CNT_W(CNT_W), .EOT_BIT(EOT_BIT), .IRQ_BIT(IRQ_BIT),
      .ZERO_IS_MAX(ZERO_IS_MAX)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .cap_lo(cap_lo), .cap_hi(cap_hi),
      .rsp_data(rsp_data), .base(rgn_base), .len(rgn_len),
      .last(d_last), .irq_req(d_irq)
   );

   sgw_seq_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .en(chan_en), .req_ready(rd_ready),
      .rsp_valid(rsp_valid), .rgn_done(rgn_done), .d_last(d_last),
      .d_irq(d_irq), .load(load), .adv(adv), .hi_sel(hi_sel),
      .cap_lo(cap_lo), .cap_hi(cap_hi), .req_valid(rd_valid),
      .rgn_valid(rgn_valid), .finished(tbl_end), .irq(rgn_irq)
   );

   AST_RD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> rd_addr[1:0] == 2'b00); // R1
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid && !rd_ready && chan_en |=> $stable(rd_addr)); // R2
   AST_REGION_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_valid && !rgn_done && chan_en |=> rgn_valid && $stable(rgn_base) && $stable(rgn_len)); // R3
   AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rgn_valid && ZERO_IS_MAX |-> rgn_len != '0); // R4
endmodule

// File: tb/sg_desc_walker_test.sv
`timescale 1ns/100ps
module sg_desc_walker_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ptr_wr = 1'b0;
   logic [31:0] ptr_wdata = '0;
   logic        chan_en = 1'b0;
   logic        rd_valid;
   logic        rd_ready = 1'b1;
   logic [31:0] rd_addr;
   logic        rsp_valid = 1'b0;
   logic [31:0] rsp_data = '0;
   logic        rgn_valid;
   logic [31:0] rgn_base;
   logic [16:0] rgn_len;
   logic        rgn_done = 1'b0;
   logic        tbl_end;
   logic        rgn_irq;

   sg_desc_walker uut (
      .clk(clk), .rst_n(rst_n), .ptr_wr(ptr_wr), .ptr_wdata(ptr_wdata),
      .chan_en(chan_en), .rd_valid(rd_valid), .rd_ready(rd_ready),
      .rd_addr(rd_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rgn_valid(rgn_valid), .rgn_base(rgn_base), .rgn_len(rgn_len),
      .rgn_done(rgn_done), .tbl_end(tbl_end), .rgn_irq(rgn_irq)
   );

   always #2.5 clk = ~clk;

   int          n_chk = 0;
   int          n_bad = 0;
   logic [31:0] mem [0:255];
   logic [31:0] flog [0:255];
   int          n_fetch = 0;
   int          n_irq = 0;
   int          lat = 1;

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   // memory responder and monitors, sampling between clock edges
   initial begin : responder
      logic        pend;
      int          cnt;
      logic [31:0] paddr;
      pend = 1'b0; cnt = 0; paddr = '0;
      forever begin
         @(negedge clk);
         rsp_valid = 1'b0;
         if (pend) begin
            if (cnt == 0) begin
               rsp_valid = 1'b1;
               rsp_data  = mem[paddr[9:2]];
               pend      = 1'b0;
            end else begin
               cnt--;
            end
         end
         if (rgn_irq) n_irq++;
         if (rd_valid && rd_ready && rst_n) begin
            flog[n_fetch[7:0]] = rd_addr;
            n_fetch++;
            pend  = 1'b1;
            cnt   = lat - 1;
            paddr = rd_addr;
         end
      end
   end

   task automatic put_desc(input logic [31:0] addr, input logic [31:0] base,
                           input logic [31:0] ctrl);
      mem[addr[9:2]]       = base;
      mem[addr[9:2] + 8'd1] = ctrl;
   endtask

   task automatic write_ptr(input logic [31:0] v);
      @(negedge clk); ptr_wr = 1'b1; ptr_wdata = v;
      @(negedge clk); ptr_wr = 1'b0;
   endtask

   task automatic wait_region(input string req);
      int k;
      k = 0;
      while (!rgn_valid && k < 200) begin
         @(negedge clk); k++;
      end
      chk(req, "region presented", {31'd0, rgn_valid}, 32'd1);
   endtask

   task automatic finish_region;
      rgn_done = 1'b1;
      @(negedge clk);
      rgn_done = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R2", "rd_valid after reset", {31'd0, rd_valid}, 32'd0);
      chk("R3", "rgn_valid after reset", {31'd0, rgn_valid}, 32'd0);
      chk("R6", "tbl_end after reset", {31'd0, tbl_end}, 32'd0);
      chk("R7", "rgn_irq after reset", {31'd0, rgn_irq}, 32'd0);
   endtask

   task automatic t_walk;
      int f0, i0;
      put_desc(32'h100, 32'h1000_0000, 32'h0000_0040);
      put_desc(32'h108, 32'h0000_2000, 32'h4000_0000);
      put_desc(32'h110, 32'h0000_3000, 32'hC000_0010);
      write_ptr(32'h0000_0103);
      f0 = n_fetch;
      chan_en = 1'b1;
      wait_region("R3");
      chk("R1", "first read address", flog[f0[7:0]], 32'h100);
      chk("R2", "second read address", flog[f0[7:0] + 8'd1], 32'h104);
      chk("R3", "region base", rgn_base, 32'h1000_0000);
      chk("R3", "region length", {15'd0, rgn_len}, 32'd64);
      idle(3);
      chk("R3", "region held while not done", {15'd0, rgn_len}, 32'd64);
      i0 = n_irq;
      finish_region;
      idle(1);
      chk("R7", "no irq without flag", n_irq, i0);
      wait_region("R5");
      chk("R5", "next entry address", flog[f0[7:0] + 8'd2], 32'h108);
      chk("R5", "next entry second word", flog[f0[7:0] + 8'd3], 32'h10C);
      chk("R4", "zero count length", {15'd0, rgn_len}, 32'd65536);
      chk("R3", "second region base", rgn_base, 32'h2000);
      finish_region;
      idle(1);
      chk("R7", "irq pulse count", n_irq, i0 + 1);
      wait_region("R6");
      chk("R3", "last region length", {15'd0, rgn_len}, 32'd16);
      chk("R6", "done not yet raised", {31'd0, tbl_end}, 32'd0);
      finish_region;
      idle(1);
      chk("R6", "done raised", {31'd0, tbl_end}, 32'd1);
      chk("R7", "irq on last region", n_irq, i0 + 2);
      idle(20);
      chk("R6", "no reads after end", n_fetch, f0 + 6);
      chk("R6", "no region after end", {31'd0, rgn_valid}, 32'd0);
      chk("R6", "done held", {31'd0, tbl_end}, 32'd1);
   endtask

   task automatic t_refetch;
      int f0;
      chan_en = 1'b0;
      idle(2);
      chk("R6", "done cleared by disable", {31'd0, tbl_end}, 32'd0);
      put_desc(32'h100, 32'h5555_0000, 32'h0000_0100);
      f0 = n_fetch;
      chan_en = 1'b1;
      wait_region("R8");
      chk("R8", "refetch from table start", flog[f0[7:0]], 32'h100);
      chk("R8", "fresh base from memory", rgn_base, 32'h5555_0000);
      chk("R8", "fresh length from memory", {15'd0, rgn_len}, 32'd256);
      chan_en = 1'b0;
      @(negedge clk);
      chk("R10", "region dropped on disable", {31'd0, rgn_valid}, 32'd0);
      idle(3);
      f0 = n_fetch;
      chan_en = 1'b1;
      wait_region("R10");
      chk("R10", "restart at table start", flog[f0[7:0]], 32'h100);
      chk("R10", "restart region base", rgn_base, 32'h5555_0000);
      chan_en = 1'b0;
      idle(3);
   endtask

   task automatic t_abort;
      int f0, k;
      lat = 6;
      put_desc(32'h200, 32'hAAAA_0000, 32'h8000_0020);
      put_desc(32'h300, 32'hBBBB_0000, 32'h8000_0030);
      write_ptr(32'h200);
      // abort while the first word is in flight
      f0 = n_fetch;
      chan_en = 1'b1;
      k = 0;
      while (n_fetch == f0 && k < 50) begin @(negedge clk); k++; end
      chan_en = 1'b0;
      idle(15);
      chk("R9", "no region after abort lo", {31'd0, rgn_valid}, 32'd0);
      chk("R9", "single read before abort", n_fetch, f0 + 1);
      // abort while the second word is in flight
      f0 = n_fetch;
      chan_en = 1'b1;
      k = 0;
      while (n_fetch < f0 + 2 && k < 80) begin @(negedge clk); k++; end
      chan_en = 1'b0;
      k = 0;
      repeat (15) begin
         @(negedge clk);
         if (rgn_valid) k++;
      end
      chk("R9", "response discarded after abort hi", k, 0);
      write_ptr(32'h300);
      f0 = n_fetch;
      chan_en = 1'b1;
      wait_region("R9");
      chk("R9", "restart reads table start", flog[f0[7:0]], 32'h300);
      chk("R9", "region from new table", rgn_base, 32'hBBBB_0000);
      chk("R9", "length from new table", {15'd0, rgn_len}, 32'd48);
      chan_en = 1'b0;
      idle(2);
      lat = 1;
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = '0;
      idle(4);
      rst_n = 1'b1;
      idle(2);
      t_reset;
      t_walk;
      t_refetch;
      t_abort;
      summary;
   end

   initial begin
      #(5.0 * 100000);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      summary;
   end
endmodule